// File: doc/BRIEF.md
# Character Display Controller Model

This block is a synthesizable model of the controller inside a character display. It serves as a stand-in device and as a verification target for host-side drivers. A host writes instruction bytes or data bytes over a byte-wide register-select bus. The model keeps an address counter, display-control and entry-mode state, an 80-byte display RAM and a 64-byte pattern RAM. It also keeps a scroll offset for the whole display. Pixel rendering, character glyphs and the panel itself are not modelled.

Each accepted operation raises a busy flag for a fixed number of clock cycles. Clear and home use a long time and the other operations use a short time. The cycle counts are derived from microsecond parameters, the clock rate in MHz and a divisor that shortens them for simulation: `cycles = US * CLK_MHZ / TIME_SCALE`. A host polls the status byte until the flag drops. Data reads and writes go to whichever RAM was named by the most recent address-set command.

Top module: `charDispModel`

## Requirements
- R1: An instruction (`wrEn` with `rs`=0) is decoded by its highest set bit: bit0 clear, bit1 home, bit2 entry mode, bit3 display control, bit4 cursor/display shift, bit5 function set, bit6 pattern address, bit7 display address. The lower bits are fields of that command only, and 0x00 does nothing.
- R2: Clear and home hold `busy` high for exactly LONG_US*CLK_MHZ/TIME_SCALE cycles. The first of these cycles is the one after the accepting edge.
- R3: Every other instruction, and every data read or write, holds `busy` for exactly SHORT_US*CLK_MHZ/TIME_SCALE cycles. A status read never raises `busy`.
- R4: While `busy` is high, instruction writes, data writes and data reads are ignored. A status read is still served and returns {busy, address counter[6:0]} on `dout` in the cycle after `rdEn`.
- R5: Clear fills all display RAM with 0x20, zeroes the address counter and the scroll offset, and makes the display RAM the access target.
- R6: Home zeroes the address counter and the scroll offset, targets the display RAM, and leaves RAM contents unchanged.
- R7: Entry mode bit1 selects increment (1) or decrement (0) of the address counter after each data access. With bit0 set, each display-RAM write moves `shiftOfs` by +1 when incrementing or by -1 when decrementing, modulo 40.
- R8: In two-line mode, display addresses step 0x27→0x40 and 0x67→0x00 going up, and the reverse going down. In one-line mode they step 0x4F→0x00 going up and 0x00→0x4F going down.
- R9: Pattern-address commands load bits 5..0 into the counter. The counter then wraps within 6 bits, and data accesses go to pattern RAM until a display-address, clear or home command.
- R10: Display control sets `dispOn`/`cursorOn`/`blinkOn` from bits 2/1/0. Function set sets `dataLen8`/`twoLine`/`font10` from bits 4/3/2. Entry mode sets `incMode`/`shiftEn` from bits 1/0.
- R11: Shift command bit3=0 moves the counter one step right (bit2=1) or left (bit2=0), using the R8/R9 wrap rules. Bit3=1 moves `shiftOfs` -1 for right and +1 for left, modulo 40.
- R12: A data read (`rdEn` with `rs`=1) places the byte at the counter on `dout` in the next cycle, then steps the counter as in R7.
- R13: After reset, `busy` is 0, the counter is 0, display RAM holds 0x20, the display is off, two-line 8-bit mode and increment mode are set, and `shiftOfs` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe, one cycle |
| rdEn | input | 1 | Read strobe, one cycle |
| rs | input | 1 | 0 = instruction/status, 1 = RAM data |
| din | input | 8 | Write byte |
| dout | output | 8 | Read byte, registered |
| busy | output | 1 | Execution in progress |
| dispOn | output | 1 | Display enabled |
| cursorOn | output | 1 | Cursor visible |
| blinkOn | output | 1 | Cursor blink |
| incMode | output | 1 | Counter increments after access |
| shiftEn | output | 1 | Display scrolls on write |
| dataLen8 | output | 1 | 8-bit interface selected |
| twoLine | output | 1 | Two-line mode |
| font10 | output | 1 | Tall font selected |
| shiftOfs | output | 6 | Display scroll offset, 0..39 |

## Verification
The decoder is given bytes whose low bits are full of set bits (0x0F, 0x0B, 0x3C, 0x7F). These separate highest-bit priority from an exact-match decoder. Writes are placed at the address boundaries 0x27, 0x67, 0x40, 0x00 and 0x4F in both directions and both line modes, which shows whether each wrap edge is correct. Busy lengths are counted for a long command, a short command and a data write, and traffic is sent during busy, which tells a blocking model from one that merely sets a flag. Pattern-RAM accesses at address 0x3F, followed by a display-RAM read-back, show whether the target selection and the 6-bit wrap are kept separate.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;
  localparam logic [7:0] BLANK_CODE = 8'h20;
  localparam int DISP_BYTES = 80;
  localparam int PAT_BYTES = 64;
  localparam int LINE_LEN = DISP_BYTES / 2;
  localparam int SCROLL_SPAN = LINE_LEN;

  typedef struct packed {
    logic clrAll;
    logic goHome;
    logic setPat;
    logic setDisp;
    logic wrData;
    logic rdData;
    logic rdStatus;
    logic curMove;
    logic scrShift;
    logic toRight;
  } ctlStrobe_t;
endpackage

// File: rtl/charDispCtrl.sv
module charDispCtrl
  import chardisp_pkg::*;
#(
  parameter int CLK_MHZ = 1,
  parameter int LONG_US = 1520,
  parameter int SHORT_US = 37,
  parameter int TIME_SCALE = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       rs,
  input  logic [7:0] din,
  output ctlStrobe_t stb,
  output logic       busy,
  output logic       dispOn,
  output logic       cursorOn,
  output logic       blinkOn,
  output logic       incMode,
  output logic       shiftEn,
  output logic       dataLen8,
  output logic       twoLine,
  output logic       font10
);
  localparam int LONG_CYC = LONG_US * CLK_MHZ / TIME_SCALE;
  localparam int SHORT_CYC = SHORT_US * CLK_MHZ / TIME_SCALE;
  localparam int CNT_W = $clog2(LONG_CYC + 1);

  logic [CNT_W-1:0] busyCnt;
  logic loadBusy, isLong, doFunc, doDisp, doEntry;

  assign busy = (busyCnt != '0);

  always_comb begin
    stb = '0;
    loadBusy = 1'b0;
    isLong = 1'b0;
    doFunc = 1'b0;
    doDisp = 1'b0;
    doEntry = 1'b0;
    if (wrEn) begin
      if (!busy) begin
        loadBusy = 1'b1;
        if (rs) begin
          stb.wrData = 1'b1;
        end else begin
          casez (din)
            8'b1???????: stb.setDisp = 1'b1;
            8'b01??????: stb.setPat = 1'b1;
            8'b001?????: doFunc = 1'b1;
            8'b0001????: begin
              stb.scrShift = din[3];
              stb.curMove = !din[3];
              stb.toRight = din[2];
            end
            8'b00001???: doDisp = 1'b1;
            8'b000001??: doEntry = 1'b1;
            8'b0000001?: begin stb.goHome = 1'b1; isLong = 1'b1; end
            8'b00000001: begin stb.clrAll = 1'b1; isLong = 1'b1; end
            default: loadBusy = 1'b0;
          endcase
        end
      end
    end else if (rdEn) begin
      if (!rs) begin
        stb.rdStatus = 1'b1;
      end else if (!busy) begin
        stb.rdData = 1'b1;
        loadBusy = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
      {dispOn, cursorOn, blinkOn} <= 3'b000;
      {incMode, shiftEn} <= 2'b10;
      {dataLen8, twoLine, font10} <= 3'b110;
    end else begin
      if (loadBusy) busyCnt <= isLong ? CNT_W'(LONG_CYC) : CNT_W'(SHORT_CYC);
      else if (busy) busyCnt <= busyCnt - 1'b1;
      if (doDisp) {dispOn, cursorOn, blinkOn} <= din[2:0];
      if (doEntry) {incMode, shiftEn} <= din[1:0];
      if (doFunc) {dataLen8, twoLine, font10} <= din[4:2];
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.clrAll, stb.goHome, stb.setPat, stb.setDisp, stb.wrData,
              stb.rdData, stb.rdStatus, stb.curMove, stb.scrShift})); // R1
  AST_LONG_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrAll || stb.goHome) |=> busy); // R2
  AST_STATUS_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdStatus && !busy) |=> !busy); // R3
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn) |=> ($stable(dispOn) && $stable(twoLine) && $stable(incMode))); // R4
endmodule

// File: rtl/charDispPath.sv
module charDispPath
  import chardisp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t stb,
  input  logic [7:0] din,
  input  logic       busy,
  input  logic       incMode,
  input  logic       shiftEn,
  input  logic       twoLine,
  output logic [7:0] dout,
  output logic [5:0] shiftOfs
);
  localparam logic [6:0] LINE2_BASE = 7'h40;
  localparam logic [6:0] LAST1 = 7'(LINE_LEN - 1);
  localparam logic [6:0] LAST2 = LINE2_BASE + LAST1;
  localparam logic [6:0] LAST_ONE = 7'(DISP_BYTES - 1);
  localparam logic [5:0] OFS_TOP = 6'(SCROLL_SPAN - 1);

  logic [7:0] dispMem [DISP_BYTES];
  logic [7:0] patMem [PAT_BYTES];
  logic [6:0] addrCnt, curIdx, accessNext, moveNext;
  logic patSel, idxOk;
  logic [7:0] rdByte;

  function automatic logic [6:0] stepDisp(input logic [6:0] a, input logic up, input logic two);
    if (two) begin
      if (up) return (a == LAST1) ? LINE2_BASE : (a == LAST2) ? 7'h00 : a + 7'd1;
      else return (a == LINE2_BASE) ? LAST1 : (a == 7'h00) ? LAST2 : a - 7'd1;
    end else begin
      if (up) return (a >= LAST_ONE) ? 7'h00 : a + 7'd1;
      else return (a == 7'h00) ? LAST_ONE : a - 7'd1;
    end
  endfunction

  function automatic logic [6:0] stepPat(input logic [6:0] a, input logic up);
    return {1'b0, up ? a[5:0] + 6'd1 : a[5:0] - 6'd1};
  endfunction

  function automatic logic [5:0] ofsStep(input logic [5:0] o, input logic left);
    if (left) return (o >= OFS_TOP) ? 6'd0 : o + 6'd1;
    else return (o == 6'd0) ? OFS_TOP : o - 6'd1;
  endfunction

  always_comb begin
    curIdx = twoLine ? (addrCnt[6] ? 7'(LINE_LEN) + {1'b0, addrCnt[5:0]} : {1'b0, addrCnt[5:0]})
                     : addrCnt;
    idxOk = curIdx < 7'(DISP_BYTES);
    rdByte = patSel ? patMem[addrCnt[5:0]] : (idxOk ? dispMem[curIdx] : BLANK_CODE);
    accessNext = patSel ? stepPat(addrCnt, incMode) : stepDisp(addrCnt, incMode, twoLine);
    moveNext = patSel ? stepPat(addrCnt, stb.toRight) : stepDisp(addrCnt, stb.toRight, twoLine);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrCnt <= '0;
      patSel <= 1'b0;
      shiftOfs <= '0;
      dout <= '0;
      for (int i = 0; i < DISP_BYTES; i++) dispMem[i] <= BLANK_CODE;
    end else begin
      if (stb.clrAll) begin
        for (int i = 0; i < DISP_BYTES; i++) dispMem[i] <= BLANK_CODE;
        addrCnt <= '0;
        patSel <= 1'b0;
        shiftOfs <= '0;
      end
      if (stb.goHome) begin
        addrCnt <= '0;
        patSel <= 1'b0;
        shiftOfs <= '0;
      end
      if (stb.setPat) begin
        addrCnt <= {1'b0, din[5:0]};
        patSel <= 1'b1;
      end
      if (stb.setDisp) begin
        addrCnt <= din[6:0];
        patSel <= 1'b0;
      end
      if (stb.wrData) begin
        if (!patSel && idxOk) dispMem[curIdx] <= din;
        addrCnt <= accessNext;
        if (shiftEn && !patSel) shiftOfs <= ofsStep(shiftOfs, incMode);
      end
      if (stb.rdData) begin
        dout <= rdByte;
        addrCnt <= accessNext;
      end
      if (stb.rdStatus) dout <= {busy, addrCnt};
      if (stb.curMove) addrCnt <= moveNext;
      if (stb.scrShift) shiftOfs <= ofsStep(shiftOfs, !stb.toRight);
    end
  end

  always_ff @(posedge clk) begin
    if (stb.wrData && patSel) patMem[addrCnt[5:0]] <= din;
  end

  AST_PAT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    patSel |-> !addrCnt[6]); // R9
  AST_TWOLINE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrData && !patSel && twoLine && incMode && addrCnt == LAST1) |=> addrCnt == LINE2_BASE); // R8
  AST_OFS_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    shiftOfs <= OFS_TOP); // R7
  AST_HOME_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    stb.goHome |=> (addrCnt == 7'h00 && shiftOfs == 6'd0)); // R6
endmodule

// File: rtl/charDispModel.sv
module charDispModel
  import chardisp_pkg::*;
#(
  parameter int CLK_MHZ = 1,
  parameter int LONG_US = 1520,
  parameter int SHORT_US = 37,
  parameter int TIME_SCALE = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       rs,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       busy,
  output logic       dispOn,
  output logic       cursorOn,
  output logic       blinkOn,
  output logic       incMode,
  output logic       shiftEn,
  output logic       dataLen8,
  output logic       twoLine,
  output logic       font10,
  output logic [5:0] shiftOfs
);
  ctlStrobe_t stb;

  charDispCtrl #(
    .CLK_MHZ(CLK_MHZ), .LONG_US(LONG_US), .SHORT_US(SHORT_US), .TIME_SCALE(TIME_SCALE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .rs(rs), .din(din),
    .stb(stb), .busy(busy), .dispOn(dispOn), .cursorOn(cursorOn), .blinkOn(blinkOn),
    .incMode(incMode), .shiftEn(shiftEn), .dataLen8(dataLen8), .twoLine(twoLine),
    .font10(font10)
  );

  charDispPath u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .din(din), .busy(busy), .incMode(incMode),
    .shiftEn(shiftEn), .twoLine(twoLine), .dout(dout), .shiftOfs(shiftOfs)
  );
endmodule

// File: tb/test_charDispModel.sv
module test_charDispModel;
  localparam int CLK_PERIOD = 10;
  localparam int TIME_SCALE = 4;
  localparam int LONG_CYC = 1520 * 1 / TIME_SCALE;
  localparam int SHORT_CYC = 37 * 1 / TIME_SCALE;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, rdEn = 1'b0, rs = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic busy, dispOn, cursorOn, blinkOn, incMode, shiftEn, dataLen8, twoLine, font10;
  logic [5:0] shiftOfs;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  charDispModel #(.TIME_SCALE(TIME_SCALE)) i_charDispModel (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .rs(rs), .din(din), .dout(dout),
    .busy(busy), .dispOn(dispOn), .cursorOn(cursorOn), .blinkOn(blinkOn), .incMode(incMode),
    .shiftEn(shiftEn), .dataLen8(dataLen8), .twoLine(twoLine), .font10(font10),
    .shiftOfs(shiftOfs)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic drive(input logic rsv, input logic [7:0] b);
    @(negedge clk); rs = rsv; din = b; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] b);
    drive(1'b0, b); waitIdle();
  endtask

  task automatic dat(input logic [7:0] b);
    drive(1'b1, b); waitIdle();
  endtask

  task automatic rdStat(output logic [7:0] v);
    @(negedge clk); rs = 1'b0; rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0; v = dout;
  endtask

  task automatic rdDat(output logic [7:0] v);
    @(negedge clk); rs = 1'b1; rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0; v = dout;
    waitIdle();
  endtask

  task automatic busyLen(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic testReset();
    logic [7:0] v;
    check("R13 busy", busy, 0);
    check("R13 flags", {dispOn, cursorOn, blinkOn, dataLen8, twoLine, font10, incMode, shiftEn}, 8'b000_110_10);
    check("R13 shiftOfs", shiftOfs, 0);
    rdStat(v); check("R13 status", v, 8'h00);
    rdDat(v); check("R13 blank ram", v, 8'h20);
  endtask

  task automatic testTiming();
    logic [7:0] v; int n;
    drive(1'b0, 8'h01); busyLen(n); check("R2 clear busy length", n, LONG_CYC);
    drive(1'b1, 8'h41); busyLen(n); check("R3 data write busy length", n, SHORT_CYC);
    drive(1'b0, 8'h0F); busyLen(n); check("R3 instruction busy length", n, SHORT_CYC);
    dat(8'h42);
    rdStat(v); check("R3 status address", v, 8'h02);
    check("R3 no busy after status", busy, 0);
  endtask

  task automatic testBlocked();
    logic [7:0] v;
    drive(1'b0, 8'h90);
    drive(1'b0, 8'h85);
    drive(1'b1, 8'h55);
    rdStat(v); check("R4 status during busy", v, 8'h90);
    waitIdle();
    rdStat(v); check("R4 ignored address set", v, 8'h10);
    rdDat(v); check("R4 ignored data write", v, 8'h20);
  endtask

  task automatic testDecode();
    cmd(8'h0F); check("R1 R10 display ctl 0x0F", {dispOn, cursorOn, blinkOn}, 3'b111);
    cmd(8'h0B); check("R1 R10 display ctl 0x0B", {dispOn, cursorOn, blinkOn}, 3'b011);
    cmd(8'h3C); check("R1 R10 function 0x3C", {dataLen8, twoLine, font10}, 3'b111);
    cmd(8'h20); check("R10 function 0x20", {dataLen8, twoLine, font10}, 3'b000);
    cmd(8'h38); check("R10 function 0x38", {dataLen8, twoLine, font10}, 3'b110);
    cmd(8'h07); check("R1 R10 entry 0x07", {incMode, shiftEn}, 2'b11);
    cmd(8'h06); check("R10 entry 0x06", {incMode, shiftEn}, 2'b10);
  endtask

  task automatic testWrap();
    logic [7:0] v;
    cmd(8'hA7); dat(8'h78); rdStat(v); check("R8 up 0x27", v, 8'h40);
    cmd(8'hE7); dat(8'h79); rdStat(v); check("R8 up 0x67", v, 8'h00);
    cmd(8'h04);
    cmd(8'hC0); dat(8'h7A); rdStat(v); check("R8 down 0x40", v, 8'h27);
    cmd(8'h80); dat(8'h7B); rdStat(v); check("R8 down 0x00", v, 8'h67);
    cmd(8'h06);
    cmd(8'hC0); rdDat(v); check("R8 data at 0x40", v, 8'h7A);
    cmd(8'h30); cmd(8'hCF); dat(8'h11); rdStat(v); check("R8 one-line up 0x4F", v, 8'h00);
    cmd(8'h04); dat(8'h12); rdStat(v); check("R8 one-line down 0x00", v, 8'h4F);
    cmd(8'h06); cmd(8'h38);
  endtask

  task automatic testShiftHome();
    logic [7:0] v; int n;
    cmd(8'h07); cmd(8'h80); dat(8'h01); dat(8'h02);
    check("R7 scroll on increment", shiftOfs, 2);
    cmd(8'h05); dat(8'h03);
    check("R7 scroll on decrement", shiftOfs, 1);
    rdStat(v); check("R7 decrement address", v, 8'h01);
    drive(1'b0, 8'h02); busyLen(n); check("R2 home busy length", n, LONG_CYC);
    rdStat(v); check("R6 home address", v, 8'h00);
    check("R6 home offset", shiftOfs, 0);
    cmd(8'h06); rdDat(v); check("R6 ram kept", v, 8'h01);
  endtask

  task automatic testCursor();
    logic [7:0] v;
    cmd(8'h14); rdStat(v); check("R11 cursor right", v, 8'h02);
    cmd(8'h10); rdStat(v); check("R11 cursor left", v, 8'h01);
    cmd(8'h18); check("R11 scroll left", shiftOfs, 1);
    cmd(8'h1C); check("R11 scroll right", shiftOfs, 0);
    cmd(8'h1C); check("R11 scroll wrap", shiftOfs, 39);
  endtask

  task automatic testPattern();
    logic [7:0] v;
    cmd(8'h7F); dat(8'hAA); rdStat(v); check("R9 pattern wrap", v, 8'h00);
    cmd(8'h7F); rdDat(v); check("R9 pattern read", v, 8'hAA);
    rdStat(v); check("R9 R12 read step wrap", v, 8'h00);
    cmd(8'h80); rdDat(v); check("R9 display untouched", v, 8'h01);
    rdStat(v); check("R12 read step", v, 8'h01);
  endtask

  task automatic testClear();
    logic [7:0] v;
    cmd(8'h40);
    cmd(8'h01);
    check("R5 offset cleared", shiftOfs, 0);
    rdStat(v); check("R5 address cleared", v, 8'h00);
    rdDat(v); check("R5 target display blank", v, 8'h20);
    cmd(8'hC0); rdDat(v); check("R5 line two blank", v, 8'h20);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTiming();
    testBlocked();
    testDecode();
    testWrap();
    testShiftHome();
    testCursor();
    testPattern();
    testClear();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule